// File: doc/BRIEF.md
# Accumulator ALU Instruction Executor

This block carries out the arithmetic and logic instructions of a small 16-bit signal processor that keeps a 32-bit accumulator. It accepts one instruction word at a time over a valid/ready handshake. It gathers the 16-bit operand the instruction names, then updates the accumulator together with a zero flag and a negative flag. The operand can come from a register, from a data-RAM word picked by a bank bit and an 8-bit address, from the program word that follows the opcode, or through a double-indirect path. In the double-indirect path a data-RAM value reached through a pointer becomes a program-memory address.

Every operand is placed in the upper half of the accumulator before the operation, and its lower half is zero. The data-RAM and program-memory reads go out on simple request/acknowledge ports. Pointer arithmetic, instruction fetch and program-counter advance all sit outside the block. Encodings whose operation field holds a reserved value, or whose low 13 bits match no operand form, are reported as illegal and change nothing.

Top module: `acc_alu_top`

## Requirements
- R1: The operation field is in_instr[15:13]. Value 1 subtracts, 4 adds, 5 ANDs, 6 ORs and 7 XORs. The operand shifted left by 16 is the right-hand term and the accumulator is the left-hand term, and the result is written to the accumulator.
- R2: Operation values 0 and 2 complete with done and illegal high for one cycle, and the accumulator and both flags keep their values.
- R3: Operation value 3 (compare) sets the flags from accumulator minus shifted operand and leaves the accumulator unchanged.
- R4: The negative flag is bit 31 of the 32-bit result and the zero flag is set when all 32 result bits are zero. Add and subtract wrap modulo 2^32.
- R5: Direct form: in_instr[12:9]=0011, with bank in bit 8 and word address in bits 7:0. The block raises dram_req with dram_indirect low, dram_bank equal to bit 8 and dram_addr equal to bits 7:0, and uses dram_rdata as the operand.
- R6: Immediate form: in_instr[12:0]=0x0400. The block raises prog_req with prog_addr equal to the next_pc sampled at acceptance, and uses prog_rdata as the operand.
- R7: Double-indirect form: in_instr[12:9]=0101 and in_instr[7:4]=0000, with bank in bit 8, mode in bits 3:2 and pointer in bits 1:0. The block first raises dram_req with dram_indirect high and dram_addr={4'b0,mode,pointer}. It then raises prog_req at the returned word and uses that fetch as the operand.
- R8: Register form: in_instr[12:3]=0000000001. reg_idx shows in_instr[2:0] and reg_rdata is sampled in the acceptance cycle. When REG_SRC_EN is 0 this form is illegal.
- R9: An instruction with a valid operation whose low 13 bits match none of the forms is reported as illegal and changes nothing.
- R10: in_ready is high only when no instruction is in progress. While a request is outstanding it stays high with stable address, and the accumulator and flags do not change.
- R11: After reset the accumulator is zero, both flags are low, in_ready is high and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction taken when valid |
| in_instr | input | 16 | Instruction word |
| next_pc | input | PADDR_W | Address of the word after the opcode |
| reg_idx | output | 3 | Register index for the register form |
| reg_rdata | input | DATA_W | Register value, sampled at acceptance |
| dram_req | output | 1 | Data-RAM read request |
| dram_bank | output | 1 | Data-RAM bank select |
| dram_indirect | output | 1 | Request is a pointer-based read |
| dram_addr | output | 8 | Word address, or {mode,pointer} when indirect |
| dram_ack | input | 1 | Data-RAM read completes |
| dram_rdata | input | DATA_W | Data-RAM read word |
| prog_req | output | 1 | Program-memory read request |
| prog_addr | output | PADDR_W | Program-memory address |
| prog_ack | input | 1 | Program-memory read completes |
| prog_rdata | input | DATA_W | Program-memory read word |
| acc | output | 2*DATA_W | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| done | output | 1 | One-cycle pulse when an instruction retires |
| illegal | output | 1 | With done: instruction was rejected |

## Verification
The main instance uses the defaults: 16-bit operands, a 16-bit program address and REG_SRC_EN set to 1. This exercises every operand form, acknowledge latencies from zero to two idle cycles, and wrap and zero results at the 32-bit boundary. A second instance is built with REG_SRC_EN set to 0. It only receives a register-form instruction, which reaches the generate branch that turns that form into an illegal encoding.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int INSTR_W = 16;
   localparam int RAM_AW  = 8;
   localparam int RIDX_W  = 3;

   typedef enum logic [2:0] {
      OP_RSV0 = 3'd0,
      OP_SUB  = 3'd1,
      OP_RSV2 = 3'd2,
      OP_CMP  = 3'd3,
      OP_ADD  = 3'd4,
      OP_AND  = 3'd5,
      OP_OR   = 3'd6,
      OP_XOR  = 3'd7
   } alu_op_e;

   typedef enum logic [1:0] {
      SRC_REG,
      SRC_DIRECT,
      SRC_IMMED,
      SRC_INDIRECT
   } src_e;

   typedef struct packed {
      alu_op_e             op;
      src_e                src;
      logic                bank;
      logic [RAM_AW-1:0]   field;
      logic                illegal;
   } dec_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_DWAIT,
      ST_PWAIT,
      ST_EXEC
   } state_e;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
   import acc_alu_pkg::*;
#(
   parameter bit REG_SRC_EN = 1'b1
) (
   input  logic [INSTR_W-1:0] instr_i,
   output dec_t               dec_o
);

   logic is_reg, is_imm, is_dir, is_ind, op_bad;

   generate
      if (REG_SRC_EN) begin : g_reg_src
         assign is_reg = (instr_i[12:3] == 10'b00_0000_0001);
      end else begin : g_no_reg_src
         assign is_reg = 1'b0;
      end
   endgenerate

   assign is_imm = (instr_i[12:0] == 13'h0400);
   assign is_dir = (instr_i[12:9] == 4'b0011);
   assign is_ind = (instr_i[12:9] == 4'b0101) && (instr_i[7:4] == 4'b0000);
   assign op_bad = (instr_i[15:13] == OP_RSV0) || (instr_i[15:13] == OP_RSV2);

   always_comb begin
      dec_o.op    = alu_op_e'(instr_i[15:13]);
      dec_o.bank  = instr_i[8];
      dec_o.field = instr_i[RAM_AW-1:0];
      dec_o.src   = SRC_REG;
      if (is_imm)      dec_o.src = SRC_IMMED;
      else if (is_dir) dec_o.src = SRC_DIRECT;
      else if (is_ind) dec_o.src = SRC_INDIRECT;
      dec_o.illegal = op_bad || !(is_reg || is_imm || is_dir || is_ind);
   end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int ACC_W = 2 * DATA_W
) (
   input  logic [ACC_W-1:0]  acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  alu_op_e           op_i,
   output logic [ACC_W-1:0]  res_o,
   output logic              wr_o,
   output logic              z_o,
   output logic              n_o
);

   logic [ACC_W-1:0] rhs;

   assign rhs = {opnd_i, {DATA_W{1'b0}}};

   always_comb begin
      unique case (op_i)
         OP_SUB, OP_CMP: res_o = acc_i - rhs;
         OP_ADD:         res_o = acc_i + rhs;
         OP_AND:         res_o = acc_i & rhs;
         OP_OR:          res_o = acc_i | rhs;
         OP_XOR:         res_o = acc_i ^ rhs;
         default:        res_o = acc_i;
      endcase
   end

   assign wr_o = (op_i != OP_CMP);
   assign z_o  = (res_o == '0);
   assign n_o  = res_o[ACC_W-1];

endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
   import acc_alu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int PADDR_W    = 16,
   parameter bit REG_SRC_EN = 1'b1,
   localparam int ACC_W     = 2 * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [15:0]        in_instr,
   input  logic [PADDR_W-1:0] next_pc,
   output logic [2:0]         reg_idx,
   input  logic [DATA_W-1:0]  reg_rdata,
   output logic               dram_req,
   output logic               dram_bank,
   output logic               dram_indirect,
   output logic [7:0]         dram_addr,
   input  logic               dram_ack,
   input  logic [DATA_W-1:0]  dram_rdata,
   output logic               prog_req,
   output logic [PADDR_W-1:0] prog_addr,
   input  logic               prog_ack,
   input  logic [DATA_W-1:0]  prog_rdata,
   output logic [ACC_W-1:0]   acc,
   output logic               flag_z,
   output logic               flag_n,
   output logic               done,
   output logic               illegal
);

   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("acc_alu_top: DATA_W must be at least 8");
      end
      if (PADDR_W > DATA_W || PADDR_W < 1) begin : g_bad_paddr_w
         $error("acc_alu_top: PADDR_W must lie in 1..DATA_W");
      end
   endgenerate

   dec_t              dec;
   state_e            st_q;
   alu_op_e           op_q;
   logic [DATA_W-1:0] opnd_q;
   logic              bank_q, ind_q;
   logic [RAM_AW-1:0] daddr_q;
   logic [PADDR_W-1:0] paddr_q;
   logic [ACC_W-1:0]  acc_q, res;
   logic              z_q, n_q, done_q, ill_q;
   logic              res_wr, res_z, res_n;

   acc_alu_decode #(.REG_SRC_EN(REG_SRC_EN)) u_dec (
      .instr_i (in_instr),
      .dec_o   (dec)
   );

   acc_alu_core #(.DATA_W(DATA_W)) u_core (
      .acc_i  (acc_q),
      .opnd_i (opnd_q),
      .op_i   (op_q),
      .res_o  (res),
      .wr_o   (res_wr),
      .z_o    (res_z),
      .n_o    (res_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         op_q    <= OP_ADD;
         opnd_q  <= '0;
         bank_q  <= 1'b0;
         ind_q   <= 1'b0;
         daddr_q <= '0;
         paddr_q <= '0;
         acc_q   <= '0;
         z_q     <= 1'b0;
         n_q     <= 1'b0;
         done_q  <= 1'b0;
         ill_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         ill_q  <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (in_valid) begin
                  op_q <= dec.op;
                  if (dec.illegal) begin
                     done_q <= 1'b1;
                     ill_q  <= 1'b1;
                  end else begin
                     unique case (dec.src)
                        SRC_REG: begin
                           opnd_q <= reg_rdata;
                           st_q   <= ST_EXEC;
                        end
                        SRC_DIRECT: begin
                           bank_q  <= dec.bank;
                           daddr_q <= dec.field;
                           ind_q   <= 1'b0;
                           st_q    <= ST_DWAIT;
                        end
                        SRC_IMMED: begin
                           paddr_q <= next_pc;
                           st_q    <= ST_PWAIT;
                        end
                        SRC_INDIRECT: begin
                           bank_q  <= dec.bank;
                           daddr_q <= {4'b0000, dec.field[3:0]};
                           ind_q   <= 1'b1;
                           st_q    <= ST_DWAIT;
                        end
                        default: st_q <= ST_IDLE;
                     endcase
                  end
               end
            end
            ST_DWAIT: begin
               if (dram_ack) begin
                  if (ind_q) begin
                     paddr_q <= dram_rdata[PADDR_W-1:0];
                     st_q    <= ST_PWAIT;
                  end else begin
                     opnd_q <= dram_rdata;
                     st_q   <= ST_EXEC;
                  end
               end
            end
            ST_PWAIT: begin
               if (prog_ack) begin
                  opnd_q <= prog_rdata;
                  st_q   <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               if (res_wr) acc_q <= res;
               z_q    <= res_z;
               n_q    <= res_n;
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign in_ready      = (st_q == ST_IDLE);
   assign reg_idx       = in_instr[RIDX_W-1:0];
   assign dram_req      = (st_q == ST_DWAIT);
   assign dram_bank     = bank_q;
   assign dram_indirect = ind_q;
   assign dram_addr     = daddr_q;
   assign prog_req      = (st_q == ST_PWAIT);
   assign prog_addr     = paddr_q;
   assign acc           = acc_q;
   assign flag_z        = z_q;
   assign flag_n        = n_q;
   assign done          = done_q;
   assign illegal       = ill_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int DATA_W  = 16,
   parameter int PADDR_W = 16,
   localparam int ACC_W  = 2 * DATA_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic [15:0]        in_instr,
   input logic               dram_req,
   input logic               dram_bank,
   input logic [7:0]         dram_addr,
   input logic               dram_ack,
   input logic               prog_req,
   input logic [PADDR_W-1:0] prog_addr,
   input logic               prog_ack,
   input logic [ACC_W-1:0]   acc,
   input logic               flag_z,
   input logic               flag_n,
   input logic               done,
   input logic               illegal
);

   logic [2:0] last_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      last_op <= 3'd0;
      else if (in_valid && in_ready)   last_op <= in_instr[15:13];
   end

   // R10
   dram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_req && !dram_ack) |=> (dram_req && $stable(dram_addr) && $stable(dram_bank)));

   // R10
   prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req && !prog_ack) |=> (prog_req && $stable(prog_addr)));

   // R10
   fetch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_req || prog_req) |=> ($stable(acc) && $stable(flag_z) && $stable(flag_n)));

   // R10
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!dram_req && !prog_req));

   // R10
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dram_req, prog_req}));

   // R2
   illegal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> done);

   // R2
   illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> ($stable(acc) && $stable(flag_z) && $stable(flag_n)));

   // R3
   cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !illegal && last_op == 3'd3) |-> $stable(acc));

   // R4
   flag_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !illegal && last_op != 3'd3) |->
         ((flag_n == acc[ACC_W-1]) && (flag_z == (acc == '0))));

endmodule

bind acc_alu_top acc_alu_chk #(.DATA_W(DATA_W), .PADDR_W(PADDR_W)) u_chk (.*);

// File: tb/acc_alu_top_tb_top.sv
`timescale 1ns/100ps
module acc_alu_top_tb_top;

   localparam int NV = 14;
   // fields: instr[36:21] regv[20:5] kind[4:3] lat[2:1] ill[0]; kind 0 reg,1 direct,2 immed,3 indirect
   localparam logic [36:0] VECS [NV] = '{
      {16'h8009, 16'h1234, 2'd0, 2'd0, 1'b0},
      {16'h8400, 16'h0000, 2'd2, 2'd0, 1'b0},
      {16'h6610, 16'h0000, 2'd1, 2'd1, 1'b0},
      {16'h2B09, 16'h0000, 2'd3, 2'd2, 1'b0},
      {16'hA7F3, 16'h0000, 2'd1, 2'd0, 1'b0},
      {16'hC00D, 16'h0F0F, 2'd0, 2'd0, 1'b0},
      {16'hE400, 16'h0000, 2'd2, 2'd1, 1'b0},
      {16'h0008, 16'h5555, 2'd0, 2'd0, 1'b1},
      {16'h4610, 16'h0000, 2'd1, 2'd0, 1'b1},
      {16'h8001, 16'h0000, 2'd0, 2'd0, 1'b1},
      {16'h8A10, 16'h0000, 2'd3, 2'd0, 1'b1},
      {16'h6A03, 16'h0000, 2'd3, 2'd1, 1'b0},
      {16'h2400, 16'h0000, 2'd2, 2'd2, 1'b0},
      {16'hE67F, 16'h0000, 2'd1, 2'd0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        in_valid = 1'b0, in_ready;
   logic [15:0] in_instr = '0, next_pc = '0, reg_rdata = '0;
   logic [2:0]  reg_idx;
   logic        dram_req, dram_bank, dram_indirect, dram_ack = 1'b0;
   logic [7:0]  dram_addr;
   logic [15:0] dram_rdata = '0, prog_addr, prog_rdata = '0;
   logic        prog_req, prog_ack = 1'b0;
   logic [31:0] acc;
   logic        flag_z, flag_n, done, illegal;

   acc_alu_top dut_i (
      .clk, .rst_n, .in_valid, .in_ready, .in_instr, .next_pc, .reg_idx, .reg_rdata,
      .dram_req, .dram_bank, .dram_indirect, .dram_addr, .dram_ack, .dram_rdata,
      .prog_req, .prog_addr, .prog_ack, .prog_rdata, .acc, .flag_z, .flag_n,
      .done, .illegal
   );

   logic        nr_valid = 1'b0, nr_ready, nr_dreq, nr_dbank, nr_dind, nr_preq;
   logic [2:0]  nr_ridx;
   logic [7:0]  nr_daddr;
   logic [15:0] nr_paddr;
   logic [31:0] nr_acc;
   logic        nr_z, nr_n, nr_done, nr_ill;

   acc_alu_top #(.REG_SRC_EN(1'b0)) dut_nr (
      .clk, .rst_n, .in_valid(nr_valid), .in_ready(nr_ready), .in_instr, .next_pc,
      .reg_idx(nr_ridx), .reg_rdata, .dram_req(nr_dreq), .dram_bank(nr_dbank),
      .dram_indirect(nr_dind), .dram_addr(nr_daddr), .dram_ack(1'b0),
      .dram_rdata(16'h0000), .prog_req(nr_preq), .prog_addr(nr_paddr),
      .prog_ack(1'b0), .prog_rdata(16'h0000), .acc(nr_acc), .flag_z(nr_z),
      .flag_n(nr_n), .done(nr_done), .illegal(nr_ill)
   );

   int n_chk = 0, n_fail = 0;
   logic [31:0] acc_m = '0;
   logic        z_m = 1'b0, n_m = 1'b0;

   function automatic logic [15:0] dram_word(logic b, logic [7:0] a);
      return {b, a[6:0], a};
   endfunction
   function automatic logic [15:0] ind_word(logic b, logic [3:0] f);
      return 16'h0100 + 16'({b, f}) * 16'd3;
   endfunction
   function automatic logic [15:0] prog_word(logic [15:0] a);
      return a ^ 16'hC35A;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // model: apply one legal operation to the reference accumulator
   task automatic model(input logic [2:0] op, input logic [15:0] v);
      logic [31:0] r, s;
      s = {v, 16'h0000};
      case (op)
         3'd1, 3'd3: r = acc_m - s;
         3'd4:       r = acc_m + s;
         3'd5:       r = acc_m & s;
         3'd6:       r = acc_m | s;
         default:    r = acc_m ^ s;
      endcase
      if (op != 3'd3) acc_m = r;
      z_m = (r == 32'h0);
      n_m = r[31];
   endtask

   task automatic run_one(input logic [15:0] ins, input logic [15:0] rv, input logic [1:0] kind,
                          input logic [1:0] lat, input bit ill, input logic [15:0] pc);
      logic [15:0] opnd, exp_paddr;
      int guard;
      @(negedge clk);
      in_instr = ins; reg_rdata = rv; next_pc = pc; in_valid = 1'b1;
      check(in_ready == 1'b1, "R10 ready when idle", 32'(in_ready), 32'd1);
      if (!ill && kind == 2'd0)
         check(reg_idx == ins[2:0], "R8 register index", 32'(reg_idx), 32'(ins[2:0]));
      @(negedge clk);
      in_valid = 1'b0;
      opnd = rv;
      exp_paddr = pc;
      guard = 0;
      while (!done && guard < 40) begin
         if (dram_req && !dram_ack) begin
            check(in_ready == 1'b0 && acc == acc_m, "R10 busy and frozen while fetching", acc, acc_m);
            check(dram_bank == ins[8], "R5/R7 bank", 32'(dram_bank), 32'(ins[8]));
            if (kind == 2'd3) begin
               check(dram_indirect && dram_addr == {4'h0, ins[3:0]}, "R7 pointer request",
                     32'(dram_addr), 32'({4'h0, ins[3:0]}));
               exp_paddr = ind_word(ins[8], ins[3:0]);
               dram_rdata = exp_paddr;
            end else begin
               check(!dram_indirect && dram_addr == ins[7:0], "R5 direct address",
                     32'(dram_addr), 32'(ins[7:0]));
               opnd = dram_word(ins[8], ins[7:0]);
               dram_rdata = opnd;
            end
            repeat (lat) @(negedge clk);
            dram_ack = 1'b1;
            @(negedge clk);
            dram_ack = 1'b0;
         end else if (prog_req && !prog_ack) begin
            check(prog_addr == exp_paddr, kind == 2'd3 ? "R7 second-level address" : "R6 immediate address",
                  32'(prog_addr), 32'(exp_paddr));
            opnd = prog_word(exp_paddr);
            prog_rdata = opnd;
            repeat (lat) @(negedge clk);
            prog_ack = 1'b1;
            @(negedge clk);
            prog_ack = 1'b0;
         end else begin
            @(negedge clk);
         end
         guard++;
      end
      check(guard < 40, "R10 instruction retires", 32'(guard), 32'd40);
      if (!ill) model(ins[15:13], opnd);
      check(illegal == ill, ill ? "R2/R9 illegal reported" : "R1 legal accepted", 32'(illegal), 32'(ill));
      check(acc == acc_m, ins[15:13] == 3'd3 ? "R3 compare keeps acc" : "R1 accumulator", acc, acc_m);
      check(flag_z == z_m && flag_n == n_m, "R4 flags", 32'({flag_z, flag_n}), 32'({z_m, n_m}));
   endtask

   initial begin
      #200000;
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(acc == 32'h0 && !flag_z && !flag_n, "R11 reset acc and flags", acc, 32'h0);
      check(in_ready && !dram_req && !prog_req && !done, "R11 reset handshake",
            32'({in_ready, dram_req, prog_req, done}), 32'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) begin
         logic [36:0] v;
         v = VECS[i];
         run_one(v[36:21], v[20:5], v[4:3], v[2:1], v[0], 16'h0040 + 16'(i * 7));
      end
      // R4 zero result: XOR with the current upper half
      run_one(16'hE008, acc_m[31:16], 2'd0, 2'd0, 1'b0, 16'h0);
      check(flag_z == 1'b1 && acc == 32'h0, "R4 zero flag on all-zero result", acc, 32'h0);
      // R4 wrap: subtract one from zero
      run_one(16'h2008, 16'h0001, 2'd0, 2'd0, 1'b0, 16'h0);
      check(acc == 32'hFFFF_0000 && flag_n, "R4 subtract wraps", acc, 32'hFFFF_0000);
      // R4 wrap upward: add back to zero
      run_one(16'h8008, 16'h0001, 2'd0, 2'd0, 1'b0, 16'h0);
      check(acc == 32'h0 && flag_z && !flag_n, "R4 add wraps to zero", acc, 32'h0);
      // R8 register form rejected when disabled
      @(negedge clk);
      in_instr = 16'h8009; reg_rdata = 16'h7777; nr_valid = 1'b1;
      @(negedge clk);
      nr_valid = 1'b0;
      check(nr_done && nr_ill, "R8 register form illegal when disabled", 32'({nr_done, nr_ill}), 32'b11);
      check(nr_acc == 32'h0, "R8 disabled form leaves acc", nr_acc, 32'h0);
      finish_run();
   end

endmodule